// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Timing Generator

This block produces the four primary gate commands of a phase-shifted full bridge from a fast clock. The clock is divided into half periods of `HALF_LEN` cycles. A digital ramp counts through each half period. A one-cycle pulse marks the start of each half period, so the bridge switches at half the rate of the half-period pulses. The leading leg (outputs A and B) swaps its selection at every half-period start. The lagging leg (outputs C and D) swaps once inside each half period. It swaps at the point where the ramp plus a fixed offset reaches the control word, or earlier if the current-limit input is asserted.

Each leg turns a selection change into a break-before-make transition, using its own dead-time word counted in clock cycles. This lets zero-voltage switching be tuned separately for the two legs. Power flows while A and D, or B and C, are on together. The position of the lagging-leg swap inside the half period therefore sets the energy delivered. Analog sensing, error amplification and gate drive sit outside this block.

Top module: `psfb_phase_gen`

## Requirements
- R1: While reset is asserted or `en_i` is sampled low, all four gates and `half_start_o` are low after that edge and the ramp restarts. The first clock edge that samples `en_i` high raises `half_start_o` and begins a new half period.
- R2: While enabled, `half_start_o` is a one-cycle pulse repeating every `HALF_LEN` cycles (64 by default).
- R3: The leading-leg selection toggles on the edge that raises `half_start_o`. Selection value 1 drives A and value 0 drives B, and the first half period after enable selects A. The outgoing gate falls one cycle after the selection change. The incoming gate rises `td_lead_i`+1 cycles after it.
- R4: At every leading-leg change, A and B are both low for exactly `td_lead_i` cycles. A value of 0 gives a direct swap with no gap.
- R5: At every lagging-leg change, C and D are both low for exactly `td_lag_i` cycles, with the same fall and rise timing as R3. Selection value 1 drives C, and the first change after enable selects C. Neither leg drives any gate before its first selection change after enable.
- R6: With no current-limit event, the lagging-leg selection changes on the edge that brings the ramp to k = `ctrl_i` − `OFFSET` (4 by default), counted in cycles from the half-start edge.
- R7: A control word at or below `OFFSET` gives k = 0. The lagging leg then changes on the same edge as the leading leg.
- R8: The phase position is capped at `MAX_POS` = floor(`HALF_LEN`·97/100), which is 62 by default, for any larger control word.
- R9: If `ilim_i` is sampled high at an edge of a half period in which the lagging leg has not yet changed, the lagging leg changes on that edge without waiting for the comparison.
- R10: The lagging leg changes at most once per half period. Further current-limit pulses and comparison crossings are ignored until the next half-period start.
- R11: A and B are never high together, and C and D are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock; one ramp step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low holds all gates off |
| ctrl_i | input | RAMP_W | Phase control word, unsigned |
| ilim_i | input | 1 | Cycle-by-cycle current-limit request |
| td_lead_i | input | DT_W | Leading-leg (A/B) dead time in cycles |
| td_lag_i | input | DT_W | Lagging-leg (C/D) dead time in cycles |
| gate_a_o | output | 1 | Leading-leg gate, selection 1 |
| gate_b_o | output | 1 | Leading-leg gate, selection 0 |
| gate_c_o | output | 1 | Lagging-leg gate, selection 1 |
| gate_d_o | output | 1 | Lagging-leg gate, selection 0 |
| half_start_o | output | 1 | One-cycle pulse at each half-period start |

## Verification
`half_start_o` and both leg selections change on the same edge that samples the inputs causing them. The current-limit input also acts on the edge that samples it. Each gate reaches the pins one cycle later for the outgoing side, and `td`+1 cycles later for the incoming side. A driver task applies inputs for each edge and computes the expected five-output vector for the state just after that edge from these latencies. It queues that vector, and a monitor compares it with the pins on the following falling edge, so every cycle is checked at its due time. Scenarios hold each leg's transitions far enough apart that no two overlap within a dead time.

// File: rtl/psfb_pkg.sv
`timescale 1ns/1ps
package psfb_pkg;

    localparam int NUM_LEGS = 2;
    localparam int LEAD_IDX = 0;
    localparam int LAG_IDX  = 1;

    // break-before-make progress of one leg
    typedef enum logic [1:0] {
        LEG_IDLE  = 2'd0,
        LEG_GAP   = 2'd1,
        LEG_DRIVE = 2'd2
    } leg_phase_e;

endpackage

// File: rtl/psfb_ramp.sv
`timescale 1ns/1ps
module psfb_ramp #(
    parameter int RAMP_W   = 8,
    parameter int HALF_LEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    output logic [RAMP_W-1:0] ramp_q_o,
    output logic [RAMP_W-1:0] ramp_next_o,
    output logic              wrap_o,
    output logic              half_o,
    output logic              lead_o
);

    localparam logic [RAMP_W-1:0] LAST_R = RAMP_W'(HALF_LEN - 1);

    typedef struct packed {
        logic [RAMP_W-1:0] ramp;
        logic              live;
        logic              half;
        logic              lead;
    } ramp_st_t;

    ramp_st_t st_d, st_q;
    logic     wrap;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (!en_i) begin
            st_d = '0;
        end else begin
            // first enabled cycle or end of ramp opens a new half period
            wrap      = !st_q.live || (st_q.ramp == LAST_R);
            st_d.live = 1'b1;
            st_d.ramp = wrap ? '0 : st_q.ramp + RAMP_W'(1);
            st_d.half = wrap;
            st_d.lead = wrap ? ~st_q.lead : st_q.lead;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ramp_q_o    = st_q.ramp;
    assign ramp_next_o = st_d.ramp;
    assign wrap_o      = wrap;
    assign half_o      = st_q.half;
    assign lead_o      = st_q.lead;

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (st_q.ramp == '0 && !st_q.half && !st_q.lead)); // R1

    AST_HALF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.half |=> !st_q.half); // R2

    AST_RAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ramp <= LAST_R); // R2

    AST_LEAD_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && (st_q.lead != $past(st_q.lead))) |-> st_q.half); // R3

endmodule

// File: rtl/psfb_lag_trip.sv
`timescale 1ns/1ps
module psfb_lag_trip #(
    parameter int RAMP_W  = 8,
    parameter int OFFSET  = 4,
    parameter int MAX_POS = 62
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [RAMP_W-1:0] ctrl_i,
    input  logic              ilim_i,
    input  logic [RAMP_W-1:0] ramp_i,
    input  logic [RAMP_W-1:0] ramp_next_i,
    input  logic              wrap_i,
    output logic              lag_o
);

    localparam logic [RAMP_W:0]   OFS_X = (RAMP_W + 1)'(OFFSET);
    localparam logic [RAMP_W-1:0] CAP_R = RAMP_W'(MAX_POS);

    typedef struct packed {
        logic tripped;
        logic lag;
    } trip_st_t;

    trip_st_t st_d, st_q;
    logic     cmp_hit;
    logic     at_cap;
    logic     hit;
    logic     fire;

    always_comb begin
        // compare against the ramp value that the coming edge will load
        cmp_hit = ({1'b0, ramp_next_i} + OFS_X) >= {1'b0, ctrl_i};
        at_cap  = (ramp_next_i == CAP_R);
        hit     = cmp_hit || ilim_i || at_cap;
        fire    = hit && (wrap_i || !st_q.tripped);
        st_d    = st_q;
        if (!en_i) begin
            st_d = '0;
        end else begin
            st_d.tripped = wrap_i ? hit : (st_q.tripped | hit);
            if (fire) st_d.lag = ~st_q.lag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lag_o = st_q.lag;

    AST_CAP_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (ramp_i > CAP_R)) |-> st_q.tripped); // R8

    AST_ILIM_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ilim_i && (wrap_i || !st_q.tripped)) |=> (st_q.lag != $past(st_q.lag))); // R9

    AST_ONE_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_q.tripped && !wrap_i) |=> (st_q.lag == $past(st_q.lag))); // R10

endmodule

// File: rtl/psfb_dead_leg.sv
`timescale 1ns/1ps
module psfb_dead_leg
    import psfb_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            sel_i,
    input  logic [DT_W-1:0] dt_i,
    output logic            hi_o,
    output logic            lo_o
);

    typedef struct packed {
        logic            seen;
        logic [DT_W-1:0] cnt;
        logic            hi;
        logic            lo;
    } leg_st_t;

    leg_st_t    st_d, st_q;
    leg_phase_e phase;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = '0;
        end else if (sel_i != st_q.seen) begin
            st_d.seen = sel_i;
            if (dt_i == '0) begin
                st_d.cnt = '0;
                st_d.hi  = sel_i;
                st_d.lo  = ~sel_i;
            end else begin
                st_d.cnt = dt_i;
                st_d.hi  = 1'b0;
                st_d.lo  = 1'b0;
            end
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - DT_W'(1);
            if (st_q.cnt == DT_W'(1)) begin
                st_d.hi = st_q.seen;
                st_d.lo = ~st_q.seen;
            end
        end
    end

    always_comb begin
        if (st_q.cnt != '0)            phase = LEG_GAP;
        else if (st_q.hi || st_q.lo)   phase = LEG_DRIVE;
        else                           phase = LEG_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi_o = st_q.hi;
    assign lo_o = st_q.lo;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.hi && st_q.lo)); // R11

    AST_GAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == LEG_GAP) |-> (!hi_o && !lo_o)); // R4 R5

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (!hi_o && !lo_o)); // R1

endmodule

// File: rtl/psfb_phase_gen.sv
`timescale 1ns/1ps
module psfb_phase_gen
    import psfb_pkg::*;
#(
    parameter int RAMP_W   = 8,
    parameter int HALF_LEN = 64,
    parameter int OFFSET   = 4,
    parameter int MAX_PCT  = 97,
    parameter int DT_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [RAMP_W-1:0] ctrl_i,
    input  logic              ilim_i,
    input  logic [DT_W-1:0]   td_lead_i,
    input  logic [DT_W-1:0]   td_lag_i,
    output logic              gate_a_o,
    output logic              gate_b_o,
    output logic              gate_c_o,
    output logic              gate_d_o,
    output logic              half_start_o
);

    localparam int MAX_POS = (HALF_LEN * MAX_PCT) / 100;

    logic [RAMP_W-1:0]   ramp_q;
    logic [RAMP_W-1:0]   ramp_next;
    logic                wrap;
    logic                lead_sel;
    logic                lag_sel;
    logic [NUM_LEGS-1:0] leg_sel;
    logic [NUM_LEGS-1:0] leg_hi;
    logic [NUM_LEGS-1:0] leg_lo;
    logic [DT_W-1:0]     leg_dt [NUM_LEGS];

    psfb_ramp #(
        .RAMP_W   (RAMP_W),
        .HALF_LEN (HALF_LEN)
    ) u_ramp (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .ramp_q_o    (ramp_q),
        .ramp_next_o (ramp_next),
        .wrap_o      (wrap),
        .half_o      (half_start_o),
        .lead_o      (lead_sel)
    );

    psfb_lag_trip #(
        .RAMP_W  (RAMP_W),
        .OFFSET  (OFFSET),
        .MAX_POS (MAX_POS)
    ) u_trip (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .ctrl_i      (ctrl_i),
        .ilim_i      (ilim_i),
        .ramp_i      (ramp_q),
        .ramp_next_i (ramp_next),
        .wrap_i      (wrap),
        .lag_o       (lag_sel)
    );

    assign leg_sel[LEAD_IDX] = lead_sel;
    assign leg_sel[LAG_IDX]  = lag_sel;
    assign leg_dt[LEAD_IDX]  = td_lead_i;
    assign leg_dt[LAG_IDX]   = td_lag_i;

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        psfb_dead_leg #(
            .DT_W (DT_W)
        ) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (en_i),
            .sel_i (leg_sel[g]),
            .dt_i  (leg_dt[g]),
            .hi_o  (leg_hi[g]),
            .lo_o  (leg_lo[g])
        );
    end

    assign gate_a_o = leg_hi[LEAD_IDX];
    assign gate_b_o = leg_lo[LEAD_IDX];
    assign gate_c_o = leg_hi[LAG_IDX];
    assign gate_d_o = leg_lo[LAG_IDX];

endmodule

// File: tb/psfb_phase_gen_bench.sv
`timescale 1ns/1ps
module psfb_phase_gen_bench;

    localparam int RW   = 8;
    localparam int HL   = 64;
    localparam int OFS  = 4;
    localparam int MPCT = 97;
    localparam int DW   = 4;
    localparam int MAXP = (HL * MPCT) / 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          ilim = 1'b0;
    logic [RW-1:0] ctrl = '0;
    logic [DW-1:0] td_lead = '0;
    logic [DW-1:0] td_lag = '0;
    logic          gate_a, gate_b, gate_c, gate_d, half_start;

    always #10 clk = ~clk;

    psfb_phase_gen #(
        .RAMP_W (RW), .HALF_LEN (HL), .OFFSET (OFS), .MAX_PCT (MPCT), .DT_W (DW)
    ) u_psfb_phase_gen (
        .clk (clk), .rst_n (rst_n), .en_i (en), .ctrl_i (ctrl), .ilim_i (ilim),
        .td_lead_i (td_lead), .td_lag_i (td_lag),
        .gate_a_o (gate_a), .gate_b_o (gate_b), .gate_c_o (gate_c), .gate_d_o (gate_d),
        .half_start_o (half_start)
    );

    typedef struct {
        logic [4:0] exp;
        string      tag;
        int         at;
    } item_t;

    typedef struct {
        bit v;
        bit pv;
        bit s;
        int tc;
        int ptc;
    } leg_m_t;

    item_t  sbq[$];
    item_t  cur;
    int     n_chk = 0;
    int     n_bad = 0;
    int     edge_n = 0;
    bit     done = 0;
    bit     m_live = 0;
    bit     m_trip = 0;
    int     m_r = 0;
    leg_m_t m_lead = '{default: 0};
    leg_m_t m_lag = '{default: 0};

    // expected {hi,lo} of a leg just after edge t, from the fall/rise timing in R3 R5
    function automatic logic [1:0] leg_exp(leg_m_t m, int t, int dt);
        if (!m.v) return 2'b00;
        if (t > m.tc) begin
            if (t >= m.tc + 1 + dt) return m.s ? 2'b10 : 2'b01;
            return 2'b00;
        end
        if (!m.pv) return 2'b00;
        if (t >= m.ptc + 1 + dt) return m.s ? 2'b01 : 2'b10;
        return 2'b00;
    endfunction

    function automatic leg_m_t leg_flip(leg_m_t m, int t);
        leg_m_t n = m;
        n.pv  = m.v;
        n.ptc = m.tc;
        n.v   = 1'b1;
        n.s   = ~m.s;
        n.tc  = t;
        return n;
    endfunction

    // driver: apply inputs for one edge, predict outputs after it, queue them
    task automatic step(input bit e, input int c, input bit il, input string tag);
        item_t nw;
        bit    hs;
        bit    wrap;
        bit    trig;
        int    k;
        en   = e;
        ctrl = c[RW-1:0];
        ilim = il;
        @(posedge clk);
        edge_n++;
        hs = 1'b0;
        if (!rst_n || !e) begin
            m_live = 0; m_r = 0; m_trip = 0;
            m_lead = '{default: 0};
            m_lag  = '{default: 0};
        end else begin
            wrap   = !m_live || (m_r == HL - 1);
            m_live = 1;
            m_r    = wrap ? 0 : m_r + 1;
            if (wrap) begin
                hs     = 1'b1;
                m_lead = leg_flip(m_lead, edge_n);
            end
            // R6 R7 R8: comparison point, R9: current limit pre-empts it
            k = (c > OFS) ? c - OFS : 0;
            if (k > MAXP) k = MAXP;
            trig = il || (m_r >= k);
            // R10: one lagging change per half period
            if (trig && (wrap || !m_trip)) m_lag = leg_flip(m_lag, edge_n);
            m_trip = wrap ? trig : (m_trip || trig);
        end
        nw.exp = {hs, leg_exp(m_lead, edge_n, int'(td_lead)), leg_exp(m_lag, edge_n, int'(td_lag))};
        nw.tag = tag;
        nw.at  = edge_n;
        sbq.push_back(nw);
        @(negedge clk);
    endtask

    // monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        if (sbq.size() != 0) begin
            cur = sbq.pop_front();
            n_chk++;
            if ({half_start, gate_a, gate_b, gate_c, gate_d} !== cur.exp) begin
                n_bad++;
                $display("FAIL %s edge %0d {hs,A,B,C,D}: actual %b expected %b",
                         cur.tag, cur.at, {half_start, gate_a, gate_b, gate_c, gate_d}, cur.exp);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual edges=%0d expected completion before 50000", edge_n);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset and disabled state
        repeat (4) step(0, 0, 0, "R1");
        rst_n = 1'b1;
        repeat (3) step(0, 20, 0, "R1");

        // R2 R3 R4 R5 R6: nominal phase, separate dead times
        td_lead = 4'd3;
        td_lag  = 4'd2;
        repeat (3 * HL) step(1, 20, 0, "R2 R3 R4 R5 R6");

        // R1: disable mid-run, then restart
        repeat (3) step(0, 20, 0, "R1");

        // R7: control at or below offset, zero dead time (R4 R5 boundary)
        td_lead = 4'd0;
        td_lag  = 4'd0;
        repeat (HL) step(1, 3, 0, "R7 R4 R5");
        repeat (HL) step(1, 4, 0, "R7");
        repeat (2) step(0, 4, 0, "R1");

        // R8: control far beyond the cap
        td_lead = 4'd1;
        td_lag  = 4'd1;
        repeat (2 * HL) step(1, 255, 0, "R8");
        repeat (2) step(0, 255, 0, "R1");

        // R9 R10: limit pulse at ramp 10, later pulses and the crossing at 36 ignored
        td_lead = 4'd2;
        td_lag  = 4'd3;
        for (int i = 0; i < 3 * HL; i++) begin
            step(1, 40, ((i % HL) == 10) || ((i % HL) == 20) || ((i % HL) == 30), "R9 R10");
        end
        repeat (2) step(0, 40, 0, "R1");

        // R10 R9 R11: limit held high, one change per half period at ramp 0
        repeat (2 * HL) step(1, 200, 1, "R10 R9 R11");
        repeat (3) step(0, 200, 0, "R1");

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule